// File: doc/BRIEF.md
# Event-Detecting GPIO Port

A 32-pin general-purpose I/O port with a word-wide register interface. Software owns an output data word and a direction word; the pad output enable follows the direction word. The pins are sampled through a two-stage synchronizer, and the synchronized level is readable as an input word. Three write-only mask registers set, clear or invert selected output bits in one access, so no read-modify-write is needed.

Every pin has its own 4-bit event mode. A mode picks an edge or level condition on the synchronized pin and what that condition drives. It can latch a sticky flag that also raises a DMA request. It can latch a flag only. It can latch a flag that raises the interrupt. Or it can drive a per-pin trigger line directly, with no flag. Flags are read as one word and cleared by writing ones. A DMA-completion pulse clears the flags of DMA-mode pins only. Two bulk configuration registers write one mode value into every pin chosen by a 16-bit mask. One register covers the lower half of the port and the other covers the upper half.

Register access uses a single-cycle write strobe and a combinational read of the addressed word. Addresses are word indices on `addr_i`.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset, the output word, direction word, flags and every pin mode are 0. `pin_o`, `pin_oe_o`, `trig_o`, `irq_o` and `dma_req_o` are 0.
- R2: The output word is read and written at address 0x00. A write to address 0x01 sets the masked output bits, 0x02 clears them and 0x03 inverts them. Unmasked bits keep their value. The write takes effect on `pin_o` at the next clock edge.
- R3: The direction word is read and written at address 0x04. `pin_oe_o` equals the direction word, where 1 means output.
- R4: Address 0x05 reads the pin levels after a two-flop synchronizer, 1 for high. A pin change is visible there after two clock edges and not after one.
- R5: Modes 0x1, 0x2 and 0x3 latch the pin's flag on a rising, falling or either edge. `dma_req_o` is high while any DMA-mode pin has its flag set. An edge sets the flag on the third clock edge after the pin changes.
- R6: Modes 0x5, 0x6 and 0x7 latch the flag on a rising, falling or either edge and raise neither `irq_o` nor `dma_req_o`.
- R7: Modes 0x9, 0xA and 0xB latch the flag on a rising, falling or either edge. `irq_o` is high while any pin in modes 0x8 to 0xC has its flag set.
- R8: Mode 0x8 latches the flag while the synchronized pin is low, and mode 0xC latches it while the pin is high. A clear issued while the level still holds leaves the flag set.
- R9: Mode 0xD drives `trig_o[n]` high while synchronized pin n is high. Mode 0xE drives it high while the pin is low. These modes never set a flag.
- R10: Flags are read at address 0x06. Writing 1 to a bit there clears that flag, and writing 0 has no effect. A flag never drops without a clear.
- R11: A one-cycle `dma_done_i` pulse clears the flags of pins in modes 0x1 to 0x3 and leaves all other flags set.
- R12: Address 0x20+n reads and writes pin n's mode in bits [3:0]. A write to 0x08 applies mode bits [19:16] to pins 0 to 15 selected by mask bits [15:0]. A write to 0x09 does the same for pins 16 to 31. Pins outside the mask keep their mode.
- R13: Modes 0x0, 0x4 and 0xF never set a flag or drive `trig_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pin_i | input | 32 | Pad input levels (asynchronous) |
| pin_o | output | 32 | Pad output levels |
| pin_oe_o | output | 32 | Pad output enables |
| dma_done_i | input | 1 | DMA transfer complete pulse |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |
| trig_o | output | 32 | Per-pin trigger outputs |

## Verification
Each pin's mode is held in its own register, so a corrupted mode appears at the ports as a flag that sets on the wrong edge or level. It can also appear as the request driven on the wrong output line. Either effect shows within three cycles of the next pin change, or of a level the pin already holds. A corrupted edge-history bit produces a spurious or missing flag on the following edge. A wrong clear priority shows up on the flag readback right after a write of ones or a `dma_done_i` pulse: a level flag drops, or a flag of the other kind is removed.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int MODE_W = 4;
  localparam int ADDR_W = 6;

  typedef enum logic [MODE_W-1:0] {
    PM_OFF      = 4'h0,
    PM_DMA_RISE = 4'h1,
    PM_DMA_FALL = 4'h2,
    PM_DMA_BOTH = 4'h3,
    PM_RSVD4    = 4'h4,
    PM_FLG_RISE = 4'h5,
    PM_FLG_FALL = 4'h6,
    PM_FLG_BOTH = 4'h7,
    PM_IRQ_LOW  = 4'h8,
    PM_IRQ_RISE = 4'h9,
    PM_IRQ_FALL = 4'hA,
    PM_IRQ_BOTH = 4'hB,
    PM_IRQ_HIGH = 4'hC,
    PM_TRIG_HI  = 4'hD,
    PM_TRIG_LO  = 4'hE,
    PM_RSVDF    = 4'hF
  } pin_mode_e;

  localparam logic [ADDR_W-1:0] A_DOUT = 6'h00;
  localparam logic [ADDR_W-1:0] A_SET  = 6'h01;
  localparam logic [ADDR_W-1:0] A_CLR  = 6'h02;
  localparam logic [ADDR_W-1:0] A_TGL  = 6'h03;
  localparam logic [ADDR_W-1:0] A_DIR  = 6'h04;
  localparam logic [ADDR_W-1:0] A_DIN  = 6'h05;
  localparam logic [ADDR_W-1:0] A_FLAG = 6'h06;
  localparam logic [ADDR_W-1:0] A_GLO  = 6'h08;
  localparam logic [ADDR_W-1:0] A_GHI  = 6'h09;
  localparam logic [ADDR_W-1:0] A_PCFG = 6'h20;

  function automatic logic is_dma_mode(logic [MODE_W-1:0] m);
    return (m >= 4'h1) && (m <= 4'h3);
  endfunction

  function automatic logic is_irq_mode(logic [MODE_W-1:0] m);
    return (m >= 4'h8) && (m <= 4'hC);
  endfunction
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_evt_out.sv
module gpio_evt_out #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dout_we_i,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic         tgl_we_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] dout_q, dir_q, dout_d;

  always_comb begin
    dout_d = dout_q;
    if (dout_we_i)     dout_d = wd_i;
    else if (set_we_i) dout_d = dout_q | wd_i;
    else if (clr_we_i) dout_d = dout_q & ~wd_i;
    else if (tgl_we_i) dout_d = dout_q ^ wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      dout_q <= dout_d;
      if (dir_we_i) dir_q <= wd_i;
    end
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/gpio_evt_pin.sv
module gpio_evt_pin
  import gpio_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wd_i,
  input  logic              lvl_i,
  input  logic              flag_clr_i,
  input  logic              dma_done_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              flag_o,
  output logic              irq_src_o,
  output logic              dma_src_o,
  output logic              trig_o
);
  logic [MODE_W-1:0] mode_q;
  logic prev_q, flag_q, rise, fall, hit, drop;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    hit = 1'b0;
    unique case (pin_mode_e'(mode_q))
      PM_DMA_RISE, PM_FLG_RISE, PM_IRQ_RISE: hit = rise;
      PM_DMA_FALL, PM_FLG_FALL, PM_IRQ_FALL: hit = fall;
      PM_DMA_BOTH, PM_FLG_BOTH, PM_IRQ_BOTH: hit = rise | fall;
      PM_IRQ_LOW:  hit = ~lvl_i;
      PM_IRQ_HIGH: hit = lvl_i;
      default:     hit = 1'b0;
    endcase
  end

  // a new event in the same cycle outranks any clear
  assign drop = flag_clr_i | (dma_done_i & is_dma_mode(mode_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= hit | (flag_q & ~drop);
      if (mode_we_i) mode_q <= mode_wd_i;
    end
  end

  assign mode_o    = mode_q;
  assign flag_o    = flag_q;
  assign irq_src_o = flag_q & is_irq_mode(mode_q);
  assign dma_src_o = flag_q & is_dma_mode(mode_q);
  assign trig_o    = ((mode_q == PM_TRIG_HI) & lvl_i) | ((mode_q == PM_TRIG_LO) & ~lvl_i);
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
  import gpio_evt_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  input  logic              dma_done_i,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic [N_PINS-1:0] trig_o
);
  localparam int HALF = N_PINS / 2;

  logic [N_PINS-1:0] lvl, flag_vec, irq_vec, dma_vec, dout, dir;
  logic [N_PINS-1:0][MODE_W-1:0] mode_vec;
  logic wr_flag, wr_glo, wr_ghi;
  logic unused_wd;

  assign unused_wd = ^wdata_i[31:20];
  assign wr_flag   = wr_en_i && (addr_i == A_FLAG);
  assign wr_glo    = wr_en_i && (addr_i == A_GLO);
  assign wr_ghi    = wr_en_i && (addr_i == A_GHI);

  gpio_evt_sync #(.W(N_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl)
  );

  gpio_evt_out #(.W(N_PINS)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dout_we_i(wr_en_i && (addr_i == A_DOUT)),
    .set_we_i (wr_en_i && (addr_i == A_SET)),
    .clr_we_i (wr_en_i && (addr_i == A_CLR)),
    .tgl_we_i (wr_en_i && (addr_i == A_TGL)),
    .dir_we_i (wr_en_i && (addr_i == A_DIR)),
    .wd_i     (wdata_i[N_PINS-1:0]),
    .dout_o   (dout),
    .dir_o    (dir)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic own_we, bulk_we;
    assign own_we = wr_en_i && (addr_i == A_PCFG + ADDR_W'(i));
    if (i < HALF) begin : g_lo
      assign bulk_we = wr_glo && wdata_i[i];
    end else begin : g_hi
      assign bulk_we = wr_ghi && wdata_i[i-HALF];
    end

    gpio_evt_pin u_pin (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_we_i (own_we | bulk_we),
      .mode_wd_i (own_we ? wdata_i[MODE_W-1:0] : wdata_i[16 +: MODE_W]),
      .lvl_i     (lvl[i]),
      .flag_clr_i(wr_flag && wdata_i[i]),
      .dma_done_i(dma_done_i),
      .mode_o    (mode_vec[i]),
      .flag_o    (flag_vec[i]),
      .irq_src_o (irq_vec[i]),
      .dma_src_o (dma_vec[i]),
      .trig_o    (trig_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1]) begin
      rdata_o[MODE_W-1:0] = mode_vec[addr_i[ADDR_W-2:0]];
    end else begin
      unique case (addr_i)
        A_DOUT:  rdata_o[N_PINS-1:0] = dout;
        A_DIR:   rdata_o[N_PINS-1:0] = dir;
        A_DIN:   rdata_o[N_PINS-1:0] = lvl;
        A_FLAG:  rdata_o[N_PINS-1:0] = flag_vec;
        default: rdata_o = '0;
      endcase
    end
  end

  assign pin_o     = dout;
  assign pin_oe_o  = dir;
  assign irq_o     = |irq_vec;
  assign dma_req_o = |dma_vec;
endmodule

// File: rtl/gpio_evt_port_chk.sv
module gpio_evt_port_chk
  import gpio_evt_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [N_PINS-1:0] pin_o,
  input logic [N_PINS-1:0] pin_oe_o,
  input logic              dma_done_i,
  input logic              irq_o,
  input logic              dma_req_o,
  input logic [N_PINS-1:0] flags_i
);
  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_SET |=> (pin_o & $past(wdata_i[N_PINS-1:0])) == $past(wdata_i[N_PINS-1:0]));

  assert_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_CLR |=> (pin_o & $past(wdata_i[N_PINS-1:0])) == '0);

  assert_tgl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_TGL |=> pin_o == ($past(pin_o) ^ $past(wdata_i[N_PINS-1:0])));

  assert_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_DIR |=> pin_oe_o == $past(wdata_i[N_PINS-1:0]));

  assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_FLAG) && !dma_done_i |=> (flags_i & $past(flags_i)) == $past(flags_i));

  assert_irq_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flags_i != '0);

  assert_dma_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> flags_i != '0);
endmodule

bind gpio_evt_port gpio_evt_port_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .dma_done_i(dma_done_i),
  .irq_o     (irq_o),
  .dma_req_o (dma_req_o),
  .flags_i   (flag_vec)
);

// File: tb/tb_gpio_evt_port.sv
module tb_gpio_evt_port;
  localparam logic [5:0] DOUT = 6'h00, SETR = 6'h01, CLRR = 6'h02, TGLR = 6'h03;
  localparam logic [5:0] DIRR = 6'h04, DINR = 6'h05, FLGR = 6'h06, GLO = 6'h08, GHI = 6'h09;
  localparam logic [5:0] PCFG = 6'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, dma_done = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe, trig;
  logic irq, dreq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_evt_port dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .dma_done_i(dma_done), .irq_o(irq), .dma_req_o(dreq), .trig_o(trig)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cleanup();
    wr(GLO, 32'h0000_FFFF);
    wr(GHI, 32'h0000_FFFF);
    pin_in = '0;
    cyc(4);
    wr(FLGR, 32'hFFFF_FFFF);
    cyc(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pin_o", pin_out, 0);
    chk("R1 pin_oe_o", pin_oe, 0);
    chk("R1 trig_o", trig, 0);
    chk("R1 irq/dma", {30'b0, irq, dreq}, 0);
    rd(FLGR, v); chk("R1 flags", v, 0);
    rd(PCFG + 6'd31, v); chk("R1 mode31", v, 0);
  endtask

  task automatic t_out();
    logic [31:0] v;
    wr(DOUT, 32'h0000_00F0);
    wr(SETR, 32'h0000_0F01); chk("R2 set", pin_out, 32'h0000_0FF1);
    wr(CLRR, 32'h0000_0030); chk("R2 clear", pin_out, 32'h0000_0FC1);
    wr(TGLR, 32'h8000_00FF); chk("R2 toggle", pin_out, 32'h8000_0F3E);
    rd(DOUT, v); chk("R2 readback", v, 32'h8000_0F3E);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(DIRR, 32'hA5A5_0F0F);
    chk("R3 oe", pin_oe, 32'hA5A5_0F0F);
    rd(DIRR, v); chk("R3 readback", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_din();
    logic [31:0] v;
    pin_in = 32'h1234_5678;
    cyc(1); rd(DINR, v); chk("R4 one edge", v, 0);
    cyc(1); rd(DINR, v); chk("R4 two edges", v, 32'h1234_5678);
    pin_in = '0; cyc(4);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    wr(PCFG + 6'd4, 1); wr(PCFG + 6'd5, 2); wr(PCFG + 6'd6, 3);
    pin_in[6:4] = 3'b111;
    cyc(2); rd(FLGR, v); chk("R5 not yet", v, 0);
    cyc(1); rd(FLGR, v); chk("R5 rise", v, 32'h50);
    chk("R5 dreq", {30'b0, irq, dreq}, 32'h1);
    pin_in[6:4] = 3'b000;
    cyc(3); rd(FLGR, v); chk("R5 fall", v, 32'h70);
    dma_done = 1'b1; cyc(1); dma_done = 1'b0;
    rd(FLGR, v); chk("R11 dma clear", v, 0);
    chk("R11 dreq low", {31'b0, dreq}, 0);
    cleanup();
  endtask

  task automatic t_flag_only();
    logic [31:0] v;
    wr(GLO, 32'h0005_0003);
    wr(PCFG + 6'd2, 7);
    rd(PCFG + 6'd1, v); chk("R12 bulk pin1", v, 5);
    rd(PCFG + 6'd3, v); chk("R12 unmasked pin3", v, 0);
    pin_in[2:0] = 3'b111;
    cyc(4); rd(FLGR, v); chk("R6 flags", v, 32'h7);
    chk("R6 no irq/dma", {30'b0, irq, dreq}, 0);
    dma_done = 1'b1; cyc(1); dma_done = 1'b0;
    rd(FLGR, v); chk("R11 non-dma kept", v, 32'h7);
    wr(FLGR, 32'h1); rd(FLGR, v); chk("R10 w1c", v, 32'h6);
    wr(FLGR, 32'h0); rd(FLGR, v); chk("R10 write zero", v, 32'h6);
    cleanup();
  endtask

  task automatic t_irq_edge();
    logic [31:0] v;
    wr(GHI, 32'h0009_8001);
    wr(PCFG + 6'd17, 32'hA); wr(PCFG + 6'd18, 32'hB);
    rd(PCFG + 6'd31, v); chk("R12 bulk pin31", v, 9);
    pin_in = 32'h8007_0000;
    cyc(4); rd(FLGR, v); chk("R7 rise", v, 32'h8005_0000);
    chk("R7 irq", {30'b0, irq, dreq}, 32'h2);
    wr(FLGR, 32'hFFFF_FFFF); chk("R7 irq clr", {31'b0, irq}, 0);
    pin_in = '0;
    cyc(4); rd(FLGR, v); chk("R7 fall", v, 32'h0006_0000);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(PCFG + 6'd3, 8);
    cyc(1); rd(FLGR, v); chk("R8 low level", v, 32'h8);
    chk("R8 irq", {31'b0, irq}, 1);
    wr(FLGR, 32'h8); rd(FLGR, v); chk("R8 reassert", v, 32'h8);
    pin_in[3] = 1'b1; cyc(3);
    wr(FLGR, 32'h8); rd(FLGR, v); chk("R8 released", v, 0);
    chk("R8 irq low", {31'b0, irq}, 0);
    wr(PCFG + 6'd7, 32'hC); pin_in[7] = 1'b1;
    cyc(3); rd(FLGR, v); chk("R8 high level", v, 32'h80);
    cleanup();
  endtask

  task automatic t_trig();
    logic [31:0] v;
    wr(PCFG + 6'd10, 32'hD); wr(PCFG + 6'd11, 32'hE);
    chk("R9 idle low", trig, 32'h0000_0800);
    pin_in[11:10] = 2'b11;
    cyc(2); chk("R9 high", trig, 32'h0000_0400);
    rd(FLGR, v); chk("R9 no flag", v, 0);
    cleanup();
  endtask

  task automatic t_nomode();
    logic [31:0] v;
    wr(PCFG + 6'd12, 4); wr(PCFG + 6'd13, 32'hF);
    pin_in[14:12] = 3'b111; cyc(4);
    pin_in[14:12] = 3'b000; cyc(4);
    rd(FLGR, v); chk("R13 no flag", v, 0);
    chk("R13 no outputs", {trig[29:0], irq, dreq}, 0);
    cleanup();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(2);
    t_reset();
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_out();
    t_dir();
    t_din();
    t_dma();
    t_flag_only();
    t_irq_edge();
    t_level();
    t_trig();
    t_nomode();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule